// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Near-Bound Flag

This block buffers 9-bit words between two unrelated clock domains. It holds 1024 words. A producer stores a word on a write-clock edge while its write enable is high. A consumer takes the oldest word on a read-clock edge while its read enable is high. The write and read pointers cross between the domains as Gray codes through two-flop synchronizers. An empty flag and a full flag, both active low, guard the two sides. An active-high half flag reports that the FIFO holds at least half its depth.

The block also has one combined near-bound flag. It rises when the FIFO is within a programmable margin X of either end. X is loaded from the write data bus by a falling edge on the active-low threshold-load input. The load input is sampled on the write clock. X takes effect only when reset is released. If the load input is high at that moment, X takes the default value of 256. A configuration state machine in the write domain controls this. It has two states:

- `CFG_HOLD`: held while reset is asserted.
- `CFG_RUN`: normal operation.

The move from `CFG_HOLD` to `CFG_RUN` happens on the first write-clock edge after the synchronized reset goes inactive. That edge commits the margin. The machine goes back to `CFG_HOLD` whenever reset is asserted. Writes are accepted only in `CFG_RUN`.

Top module: `dual_clock_thresh_fifo`

## Requirements
- R1: Words leave on `rdata` in the order they were accepted. `rdata` changes on the read-clock edge that accepts a read.
- R2: A write while `full_n` is low is dropped. The words already stored are unchanged, and no extra word is ever read out.
- R3: A read while `empty_n` is low is dropped. `rdata` keeps the last word delivered, and `empty_n` stays low.
- R4: Once both domains have settled, `empty_n` is 0 when the FIFO holds no word and 1 otherwise.
- R5: Once both domains have settled, `full_n` is 0 when the FIFO holds 1024 words and 1 otherwise.
- R6: Once both domains have settled, `half_full` is 1 for an occupancy of 512 or more and 0 for 511 or fewer.
- R7: Once both domains have settled, `near_bound` is 1 when occupancy is at most X, or at least 1024 − X. It is 0 in between.
- R8: The write clock samples `thr_load_n`. A sample of 1 followed by a sample of 0 is a falling edge, and it captures `wdata` as X (range 0 to 511). If `thr_load_n` is 0 when reset is released, the captured X is used.
- R9: If `thr_load_n` is 1 when reset is released, X becomes 256.
- R10: If `thr_load_n` stays 0 through a later reset, with no new falling edge, the earlier X is kept.
- R11: While reset is asserted and right after release, the outputs are as follows:
  - `empty_n` is 0.
  - `full_n` is 1.
  - `half_full` is 0.
  - `near_bound` is 1.
  - `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wen | input | 1 | Write request, sampled on rising `wclk` |
| wdata | input | 9 | Word to store; also the source of X on a threshold-load edge |
| rclk | input | 1 | Read-domain clock |
| ren | input | 1 | Read request, sampled on rising `rclk` |
| rdata | output | 9 | Last word read |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| thr_load_n | input | 1 | Active-low threshold-load strobe, sampled on `wclk` |
| empty_n | output | 1 | Low when the FIFO is empty (read domain) |
| full_n | output | 1 | Low when the FIFO is full (write domain) |
| half_full | output | 1 | High at 512 or more words (read domain) |
| near_bound | output | 1 | High when occupancy is within X of either end (read domain) |

## Verification
The assertions check several rules on every cycle:
- The write pointer never runs more than one depth ahead of the synchronized read pointer.
- A write refused while full leaves the pointer where it was.
- `empty_n` high always means the FIFO holds a word.
- `half_full` high always means at least half the depth is stored.
- `rdata` holds through a refused read.
- The margin does not move while running.

Some behaviour only the directed scenarios can show: exact data order, the flag values at each occupancy boundary for several margins, the three ways of setting the margin across resets, and concurrent streaming at unrelated clock rates.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    // Configuration phase of the write domain
    typedef enum logic {
        CFG_HOLD = 1'b0,
        CFG_RUN  = 1'b1
    } cfg_state_t;

endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic srst
);
    logic [1:0] stage_q;

    // Asserts at once; releases after two edges of this domain's clock
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= 2'b11;
        else         stage_q <= {stage_q[0], 1'b0};
    end

    assign srst = stage_q[1];
endmodule

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DW = 9,
    parameter int AW = 10
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Output register keeps its word when no read is accepted
    always_ff @(posedge rclk or posedge rrst) begin
        if (rrst)    rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int DW      = 9,
    parameter int AW      = 10,
    parameter int THR_DEF = 256
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wen,
    input  logic [DW-1:0] wdata,
    input  logic          thr_load_n,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic          full_n,
    output logic [AW-2:0] thr
);
    localparam int PW = AW + 1;
    localparam int TW = AW - 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;

    cfg_state_t    state_q, state_d;
    logic [PW-1:0] wbin_q, wbin_d, wgray_d, rq2_bin;
    logic          full_d;
    logic          load_prev_q;
    logic [TW-1:0] cap_q, cap_d, thr_q;

    // State register
    always_ff @(posedge wclk or posedge wrst) begin
        if (wrst) state_q <= CFG_HOLD;
        else      state_q <= state_d;
    end

    // Next state: leave hold on the first edge after reset release
    always_comb begin
        unique case (state_q)
            CFG_HOLD: state_d = CFG_RUN;
            CFG_RUN:  state_d = CFG_RUN;
        endcase
    end

    // Outputs and next values
    always_comb begin
        we      = wen && full_n && (state_q == CFG_RUN);
        cap_d   = (load_prev_q && !thr_load_n) ? wdata[TW-1:0] : cap_q;
        wbin_d  = wbin_q + PW'(we);
        wgray_d = wbin_d ^ (wbin_d >> 1);
        full_d  = !(wgray_d == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    end

    always_ff @(posedge wclk or posedge wrst) begin
        if (wrst) begin
            wbin_q <= '0;
            wgray  <= '0;
            full_n <= 1'b1;
        end else begin
            wbin_q <= wbin_d;
            wgray  <= wgray_d;
            full_n <= full_d;
        end
    end

    // Margin registers survive reset so a captured value can be kept
    always_ff @(posedge wclk) begin
        load_prev_q <= thr_load_n;
        cap_q       <= cap_d;
        if (state_q == CFG_HOLD && !wrst)
            thr_q <= thr_load_n ? TW'(THR_DEF) : cap_d;
    end

    always_comb begin
        for (int i = 0; i < PW; i++) rq2_bin[i] = ^(rgray_s >> i);
    end

    assign waddr = wbin_q[AW-1:0];
    assign thr   = thr_q;

    // R2
    no_overflow_chk: assert property (@(posedge wclk) disable iff (wrst)
        ((wbin_q - rq2_bin) <= DEPTH_P));

    // R2
    wr_ignored_chk: assert property (@(posedge wclk) disable iff (wrst)
        (!full_n && wen) |=> $stable(wbin_q));

    // R10
    thr_hold_chk: assert property (@(posedge wclk) disable iff (wrst)
        (state_q == CFG_RUN) |=> $stable(thr_q));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
    parameter int AW = 10
) (
    input  logic          rclk,
    input  logic          rrst,
    input  logic          ren,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-2:0] thr,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic          re,
    output logic          empty_n,
    output logic          half_full,
    output logic          near_bound
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;
    localparam logic [PW-1:0] HALF_P  = DEPTH_P >> 1;

    logic [PW-1:0] rbin_q, rbin_d, rgray_d, wsb, cnt_d, thr_w;
    logic          empty_d, half_d, near_d;

    always_comb begin
        for (int i = 0; i < PW; i++) wsb[i] = ^(wgray_s >> i);
    end

    always_comb begin
        thr_w   = PW'(thr);
        re      = ren && empty_n;
        rbin_d  = rbin_q + PW'(re);
        rgray_d = rbin_d ^ (rbin_d >> 1);
        empty_d = (rgray_d == wgray_s);
        cnt_d   = wsb - rbin_d;
        half_d  = (cnt_d >= HALF_P);
        near_d  = (cnt_d <= thr_w) || (cnt_d >= (DEPTH_P - thr_w));
    end

    always_ff @(posedge rclk or posedge rrst) begin
        if (rrst) begin
            rbin_q     <= '0;
            rgray      <= '0;
            empty_n    <= 1'b0;
            half_full  <= 1'b0;
            near_bound <= 1'b1;
        end else begin
            rbin_q     <= rbin_d;
            rgray      <= rgray_d;
            empty_n    <= !empty_d;
            half_full  <= half_d;
            near_bound <= near_d;
        end
    end

    assign raddr = rbin_q[AW-1:0];

    // R4
    no_underflow_chk: assert property (@(posedge rclk) disable iff (rrst)
        empty_n |-> ((wsb - rbin_q) != '0));

    // R6
    half_level_chk: assert property (@(posedge rclk) disable iff (rrst)
        half_full |-> ((wsb - rbin_q) >= HALF_P));
endmodule

// File: rtl/dual_clock_thresh_fifo.sv
module dual_clock_thresh_fifo #(
    parameter int DW      = 9,
    parameter int AW      = 10,
    parameter int THR_DEF = 256
) (
    input  logic          wclk,
    input  logic          wen,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          ren,
    output logic [DW-1:0] rdata,
    input  logic          rst_n,
    input  logic          thr_load_n,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_full,
    output logic          near_bound
);
    localparam int PW = AW + 1;

    logic          wrst, rrst, we, re;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr;
    logic [AW-2:0] thr;

    dcf_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst(wrst));
    dcf_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst(rrst));

    dcf_wr_side #(.DW(DW), .AW(AW), .THR_DEF(THR_DEF)) u_wr (
        .wclk(wclk), .wrst(wrst), .wen(wen), .wdata(wdata),
        .thr_load_n(thr_load_n), .rgray_s(rgray_s), .wgray(wgray),
        .waddr(waddr), .we(we), .full_n(full_n), .thr(thr)
    );

    dcf_rd_side #(.AW(AW)) u_rd (
        .rclk(rclk), .rrst(rrst), .ren(ren), .wgray_s(wgray_s), .thr(thr),
        .rgray(rgray), .raddr(raddr), .re(re), .empty_n(empty_n),
        .half_full(half_full), .near_bound(near_bound)
    );

    dcf_ptr_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s));
    dcf_ptr_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s));

    dcf_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
        .rclk(rclk), .rrst(rrst), .re(re), .raddr(raddr), .rdata(rdata)
    );

    // R3
    empty_read_hold_chk: assert property (@(posedge rclk) disable iff (rrst)
        (ren && !empty_n) |=> $stable(rdata));
endmodule

// File: tb/sim_dual_clock_thresh_fifo.sv
`timescale 1ns/1ps
module sim_dual_clock_thresh_fifo;
    logic       wclk = 1'b0, rclk = 1'b0;
    logic       rst_n = 1'b0, wen = 1'b0, ren = 1'b0, thr_load_n = 1'b1;
    logic [8:0] wdata = '0;
    logic [8:0] rdata;
    logic       empty_n, full_n, half_full, near_bound;

    always #2   wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    dual_clock_thresh_fifo u0 (
        .wclk(wclk), .wen(wen), .wdata(wdata), .rclk(rclk), .ren(ren),
        .rdata(rdata), .rst_n(rst_n), .thr_load_n(thr_load_n),
        .empty_n(empty_n), .full_n(full_n), .half_full(half_full),
        .near_bound(near_bound)
    );

    int         checks = 0, errors = 0;
    int         cur_x  = 256;
    logic [8:0] q[$];
    logic [8:0] seq = 9'd5;

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle;
        repeat (6) @(negedge wclk);
        repeat (6) @(negedge rclk);
    endtask

    task automatic check_level(input string tag);
        int n;
        settle();
        n = q.size();
        @(negedge rclk);
        chk(empty_n,    int'(n != 0),   {"R4 empty ", tag});
        chk(half_full,  int'(n >= 512), {"R6 half ", tag});
        chk(near_bound, int'((n <= cur_x) || (n >= 1024 - cur_x)), {"R7 near ", tag});
        @(negedge wclk);
        chk(full_n,     int'(n != 1024), {"R5 full ", tag});
    endtask

    task automatic put(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wen   = 1'b1;
            wdata = seq;
            if (q.size() < 1024) q.push_back(seq);
            seq = seq + 9'd37;
        end
        @(negedge wclk);
        wen = 1'b0;
    endtask

    task automatic fill_to(input int target);
        put(target - q.size());
    endtask

    task automatic get(input int n, input string tag);
        logic [8:0] e;
        for (int i = 0; i < n; i++) begin
            @(negedge rclk);
            ren = 1'b1;
            @(negedge rclk);
            ren = 1'b0;
            e = q.pop_front();
            chk(rdata, e, tag);
        end
    endtask

    // mode 0: default margin, 1: load x, 2: keep previous margin
    task automatic do_reset(input int mode, input logic [8:0] x);
        @(negedge wclk);
        wen = 1'b0;
        ren = 1'b0;
        if (mode == 1) begin
            thr_load_n = 1'b1;
            @(negedge wclk);
            wdata      = x;
            thr_load_n = 1'b0;
            @(negedge wclk);
            wdata      = ~x;
        end else if (mode == 0) begin
            thr_load_n = 1'b1;
        end else begin
            wdata = 9'h1FF;
        end
        rst_n = 1'b0;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        rst_n = 1'b1;
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
        q.delete();
        if (mode == 0)      cur_x = 256;
        else if (mode == 1) cur_x = int'(x);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge rclk);
        chk(empty_n, 0, "R11 empty_n in reset");
        chk(near_bound, 1, "R11 near_bound in reset");
        do_reset(0, 9'd0);
        @(negedge rclk);
        chk(empty_n,    0, "R11 empty_n after reset");
        chk(half_full,  0, "R11 half_full after reset");
        chk(near_bound, 1, "R11 near_bound after reset");
        chk(rdata,      0, "R11 rdata after reset");
        @(negedge wclk);
        chk(full_n,     1, "R11 full_n after reset");
    endtask

    task automatic t_default_levels;
        fill_to(1);    check_level("count 1");
        fill_to(256);  check_level("count 256");
        fill_to(257);  check_level("count 257");
        fill_to(511);  check_level("count 511");
        fill_to(512);  check_level("count 512");
        fill_to(767);  check_level("count 767");
        fill_to(768);  check_level("count 768");
        fill_to(1023); check_level("count 1023");
        fill_to(1024); check_level("count 1024");
    endtask

    task automatic t_overflow;
        put(3);
        check_level("R2 after writes while full");
        get(1024, "R1 R2 drain order");
        check_level("R2 drained");
        chk(empty_n, 0, "R2 extra words not stored");
    endtask

    task automatic t_underflow;
        logic [8:0] last;
        last = rdata;
        @(negedge rclk); ren = 1'b1;
        @(negedge rclk); ren = 1'b0;
        chk(rdata, last, "R3 rdata holds on empty read");
        settle();
        chk(empty_n, 0, "R3 still empty");
        put(1);
        settle();
        get(1, "R3 word after refused read");
    endtask

    task automatic t_program;
        do_reset(1, 9'd10);
        check_level("R8 x=10 count 0");
        fill_to(10);   check_level("R8 x=10 count 10");
        fill_to(11);   check_level("R8 x=10 count 11");
        fill_to(1013); check_level("R8 x=10 count 1013");
        fill_to(1014); check_level("R8 x=10 count 1014");
        get(q.size(), "R1 drain x=10");
    endtask

    task automatic t_retain;
        do_reset(2, 9'd0);
        fill_to(10); check_level("R10 kept x count 10");
        fill_to(11); check_level("R10 kept x count 11");
        get(q.size(), "R1 drain kept x");
    endtask

    task automatic t_program_max;
        thr_load_n = 1'b1;
        do_reset(1, 9'd511);
        fill_to(511); check_level("R8 x=511 count 511");
        fill_to(512); check_level("R8 x=511 count 512");
        fill_to(513); check_level("R8 x=511 count 513");
        get(q.size(), "R1 drain x=511");
    endtask

    task automatic t_default_again;
        do_reset(0, 9'd0);
        fill_to(256); check_level("R9 default count 256");
        fill_to(257); check_level("R9 default count 257");
        get(q.size(), "R1 drain default");
    endtask

    task automatic t_stream;
        fork
            begin : writer
                int         sent = 0;
                logic [7:0] lf   = 8'h5A;
                while (sent < 300) begin
                    @(negedge wclk);
                    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                    if (lf[0] && full_n) begin
                        wen   = 1'b1;
                        wdata = seq;
                        q.push_back(seq);
                        seq  = seq + 9'd37;
                        sent++;
                    end else begin
                        wen = 1'b0;
                    end
                end
                @(negedge wclk);
                wen = 1'b0;
            end
            begin : reader
                int         got  = 0;
                bit         pend = 1'b0;
                logic [7:0] lf   = 8'hC3;
                logic [8:0] e;
                while (got < 300) begin
                    @(negedge rclk);
                    if (pend) begin
                        e = q.pop_front();
                        chk(rdata, e, "R1 streaming order");
                        got++;
                    end
                    lf   = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                    pend = empty_n && (lf[0] || lf[1]) && (got < 300);
                    ren  = pend;
                end
                ren = 1'b0;
            end
        join
        check_level("R4 after stream");
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_default_levels();
        t_overflow();
        t_underflow();
        t_program();
        t_retain();
        t_program_max();
        t_default_again();
        t_stream();
        finish_run();
    end
endmodule